// File: doc/BRIEF.md
# Floating-point status register with exception recording

The block holds a 32-bit floating-point status and control word. An execution unit that has just finished an operation presents a vector of exception event flags together with an update strobe. In that same cycle the block ORs each event into its own sticky bit and raises the general exception-summary bit for any nonzero vector. It then rebuilds the invalid-operation summary and the enabled-exception summary from the sticky and enable bits now in the word, and on the next cycle it raises a trap request when the enabled-exception summary is set.

When the finished instruction has its record flag set, the four most significant bits of the updated word are also copied into a 4-bit condition field. Software can set or clear single bits and can overwrite any 4-bit nibble of the word. These are the only ways a sticky bit is ever cleared. The arithmetic that produces the event flags lies outside the block.

Event vector encoding: bit 0 overflow, bit 1 underflow, bit 2 divide by zero, bit 3 inexact, bits 4 to 12 the nine invalid-operation causes in this order: signalling NaN, infinity minus infinity, infinity over infinity, zero over zero, infinity times zero, invalid compare, software request, invalid square root, invalid integer conversion.

Top module: `fpsr_recorder`

## Requirements
- R1: An update with a nonzero event vector sets status bit 31 (any-exception). An update with a zero vector leaves bit 31 as it was.
- R2: Overflow, underflow, divide-by-zero and inexact events set status bits 28, 27, 26 and 25 respectively.
- R3: The nine invalid causes (event bits 4 to 12) set status bits 24, 23, 22, 21, 20, 19, 10, 9 and 8 respectively.
- R4: After every update, status bit 29 (invalid summary) equals the OR of the nine invalid sticky bits.
- R5: After every update, status bit 30 (enabled summary) is set exactly when at least one of these pairs is fully set: invalid summary with enable bit 7, overflow with bit 6, underflow with bit 5, divide-by-zero with bit 4, or inexact with bit 3.
- R6: trap_q is high for exactly the one cycle that follows an update whose resulting bit 30 is set. It is low in every other cycle.
- R7: An update with upd_record high loads crf_q with bits 31:28 of the updated word, taken on the same clock edge as the update.
- R8: crf_q keeps its value in every cycle that is not a recording update, including a cycle where upd_record is high without upd_valid.
- R9: An event update never clears any sticky bit (bits 31, 28 to 19, and 10 to 8).
- R10: A zero-vector update still rebuilds bits 29 and 30 from the current word. It restores a cleared invalid summary and drops an enabled summary that no pair supports.
- R11: Software bit set and bit clear act on bit sw_bit_idx, and set wins when both are given. A nibble write replaces bits 4n+3 to 4n, with n = sw_fld_idx, and overrides both bit operations. In a cycle that has both a software operation and an update, the events are applied on top of the software result.
- R12: A synchronous reset clears status_q, crf_q and trap_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Event update strobe |
| upd_events | input | 13 | Exception event flags |
| upd_record | input | 1 | Copy the high nibble into the condition field |
| sw_bit_set | input | 1 | Software set of one bit |
| sw_bit_clr | input | 1 | Software clear of one bit |
| sw_bit_idx | input | 5 | Bit index for set or clear |
| sw_fld_wr | input | 1 | Software nibble write |
| sw_fld_idx | input | 3 | Nibble index |
| sw_fld_data | input | 4 | Nibble value |
| status_q | output | 32 | Status and control word |
| crf_q | output | 4 | Condition field |
| trap_q | output | 1 | Trap request |

## Verification
The hardest case is a word whose summary bits disagree with its sticky and enable bits. Event updates never leave the word in that state, so only software writes can create it. The bench first records an invalid event, then clears the invalid summary by a software bit clear, and forces the enabled summary on with no enable set. It then issues zero-vector updates and checks that both summaries are rebuilt and that no trap is raised. The bench also combines a software write with an event update in one cycle to check that the events are applied on top of the software result.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int STAT_W = 32;
  localparam int EV_W   = 13;
  localparam int NINV   = 9;

  // status bit positions; the top four are copied to the condition field
  localparam int B_ANY = 31;
  localparam int B_EN  = 30;
  localparam int B_INV = 29;
  localparam int B_OVF = 28;
  localparam int B_UNF = 27;
  localparam int B_ZDV = 26;
  localparam int B_INX = 25;

  // enable bit positions
  localparam int E_INV = 7;
  localparam int E_OVF = 6;
  localparam int E_UNF = 5;
  localparam int E_ZDV = 4;
  localparam int E_INX = 3;

  // event vector positions
  localparam int EV_OVF  = 0;
  localparam int EV_UNF  = 1;
  localparam int EV_ZDV  = 2;
  localparam int EV_INX  = 3;
  localparam int EV_INV0 = 4;

  localparam logic [STAT_W-1:0] STICKY_MASK = 32'h9FF8_0700;
  localparam logic [STAT_W-1:0] INV_MASK    = 32'h01F8_0700;

  // invalid cause i -> sticky bit position
  function automatic int inv_pos(input int i);
    return (i < 6) ? (24 - i) : (10 - (i - 6));
  endfunction
endpackage

// File: rtl/fpsr_sw_port.sv
module fpsr_sw_port #(
  parameter int W  = 32,
  parameter int NW = 4,
  localparam int NF = W / NW,
  localparam int IW = $clog2(W),
  localparam int FW = $clog2(NF)
) (
  input  logic [W-1:0]  cur,
  input  logic          bit_set,
  input  logic          bit_clr,
  input  logic [IW-1:0] bit_idx,
  input  logic          fld_wr,
  input  logic [FW-1:0] fld_idx,
  input  logic [NW-1:0] fld_data,
  output logic [W-1:0]  nxt
);
  logic [W-1:0] bitwise;

  always_comb begin
    bitwise = cur;
    if (bit_clr) bitwise[bit_idx] = 1'b0;
    if (bit_set) bitwise[bit_idx] = 1'b1;
  end

  for (genvar g = 0; g < NF; g++) begin : g_nib
    assign nxt[g*NW +: NW] = (fld_wr && fld_idx == FW'(g)) ? fld_data
                                                          : bitwise[g*NW +: NW];
  end
endmodule

// File: rtl/fpsr_event_merge.sv
module fpsr_event_merge
  import fpsr_pkg::*;
#(
  parameter int W = STAT_W,
  parameter int E = EV_W
) (
  input  logic [W-1:0] cur,
  input  logic [E-1:0] ev,
  output logic [W-1:0] nxt,
  output logic         en_sum
);
  logic [W-1:0] s;
  logic         inv;
  logic         en;

  always_comb begin
    s = cur;
    if (|ev) s[B_ANY] = 1'b1;
    s[B_OVF] = s[B_OVF] | ev[EV_OVF];
    s[B_UNF] = s[B_UNF] | ev[EV_UNF];
    s[B_ZDV] = s[B_ZDV] | ev[EV_ZDV];
    s[B_INX] = s[B_INX] | ev[EV_INX];
    for (int i = 0; i < NINV; i++) begin
      s[inv_pos(i)] = s[inv_pos(i)] | ev[EV_INV0 + i];
    end
    inv = |(s & INV_MASK);
    s[B_INV] = inv;
    en = (inv & s[E_INV]) | (s[B_OVF] & s[E_OVF]) | (s[B_UNF] & s[E_UNF]) |
         (s[B_ZDV] & s[E_ZDV]) | (s[B_INX] & s[E_INX]);
    s[B_EN] = en;
    nxt    = s;
    en_sum = en;
  end
endmodule

// File: rtl/fpsr_recorder.sv
module fpsr_recorder
  import fpsr_pkg::*;
#(
  parameter int W   = STAT_W,
  parameter int E   = EV_W,
  parameter int CRW = 4,
  parameter int NW  = 4,
  localparam int IW = $clog2(W),
  localparam int FW = $clog2(W / NW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_valid,
  input  logic [E-1:0]  upd_events,
  input  logic          upd_record,
  input  logic          sw_bit_set,
  input  logic          sw_bit_clr,
  input  logic [IW-1:0] sw_bit_idx,
  input  logic          sw_fld_wr,
  input  logic [FW-1:0] sw_fld_idx,
  input  logic [NW-1:0] sw_fld_data,
  output logic [W-1:0]  status_q,
  output logic [CRW-1:0] crf_q,
  output logic          trap_q
);
  logic [W-1:0] sw_val;
  logic [W-1:0] merged;
  logic         en_sum;

  fpsr_sw_port #(.W(W), .NW(NW)) u_sw (
    .cur(status_q), .bit_set(sw_bit_set), .bit_clr(sw_bit_clr),
    .bit_idx(sw_bit_idx), .fld_wr(sw_fld_wr), .fld_idx(sw_fld_idx),
    .fld_data(sw_fld_data), .nxt(sw_val)
  );

  fpsr_event_merge #(.W(W), .E(E)) u_merge (
    .cur(sw_val), .ev(upd_events), .nxt(merged), .en_sum(en_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      crf_q    <= '0;
      trap_q   <= 1'b0;
    end else begin
      status_q <= upd_valid ? merged : sw_val;
      trap_q   <= upd_valid & en_sum;
      if (upd_valid && upd_record) crf_q <= merged[W-1 -: CRW];
    end
  end
endmodule

// File: rtl/fpsr_recorder_chk.sv
module fpsr_recorder_chk
  import fpsr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        upd_valid,
  input logic [12:0] upd_events,
  input logic        upd_record,
  input logic        sw_bit_clr,
  input logic        sw_fld_wr,
  input logic [31:0] status_q,
  input logic [3:0]  crf_q,
  input logic        trap_q
);
  AST_ANY_SET: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && |upd_events) |=> status_q[B_ANY]); // R1

  AST_INV_SUM: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> status_q[B_INV] == |(status_q & INV_MASK)); // R4

  AST_EN_SUM: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> status_q[B_EN] == ((status_q[B_INV] & status_q[E_INV]) |
      (status_q[B_OVF] & status_q[E_OVF]) | (status_q[B_UNF] & status_q[E_UNF]) |
      (status_q[B_ZDV] & status_q[E_ZDV]) | (status_q[B_INX] & status_q[E_INX]))); // R5

  AST_TRAP_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> trap_q == status_q[B_EN]); // R6

  AST_TRAP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !trap_q); // R6

  AST_CRF_LOAD: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_record) |=> crf_q == status_q[31:28]); // R7

  AST_CRF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(upd_valid && upd_record) |=> $stable(crf_q)); // R8

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!sw_bit_clr && !sw_fld_wr) |=>
      ((status_q & $past(status_q) & STICKY_MASK) == ($past(status_q) & STICKY_MASK))); // R9
endmodule

bind fpsr_recorder fpsr_recorder_chk u_chk (.*);

// File: tb/fpsr_recorder_test.sv
module fpsr_recorder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [12:0] upd_events = '0;
  logic        upd_record = 1'b0;
  logic        sw_bit_set = 1'b0;
  logic        sw_bit_clr = 1'b0;
  logic [4:0]  sw_bit_idx = '0;
  logic        sw_fld_wr = 1'b0;
  logic [2:0]  sw_fld_idx = '0;
  logic [3:0]  sw_fld_data = '0;
  logic [31:0] status_q;
  logic [3:0]  crf_q;
  logic        trap_q;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fpsr_recorder uut (.*);

  task automatic idle();
    upd_valid = 0; upd_events = '0; upd_record = 0;
    sw_bit_set = 0; sw_bit_clr = 0; sw_bit_idx = '0;
    sw_fld_wr = 0; sw_fld_idx = '0; sw_fld_data = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    idle(); rst = 1; cyc(); cyc(); rst = 0;
  endtask

  task automatic upd(input logic [12:0] ev, input logic rec);
    idle(); upd_valid = 1; upd_events = ev; upd_record = rec; cyc(); idle();
  endtask

  task automatic sw_set(input int idx);
    idle(); sw_bit_set = 1; sw_bit_idx = 5'(idx); cyc(); idle();
  endtask

  task automatic sw_clr(input int idx);
    idle(); sw_bit_clr = 1; sw_bit_idx = 5'(idx); cyc(); idle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 status", status_q, 32'h0);
    chk("R12 crf", {28'h0, crf_q}, 32'h0);
    chk("R12 trap", {31'h0, trap_q}, 32'h0);
  endtask

  task automatic t_basic_events();
    do_reset();
    upd(13'h001, 0);
    chk("R2 overflow", status_q, 32'h9000_0000);
    upd(13'h000, 0);
    chk("R1 zero vector keeps any", status_q, 32'h9000_0000);
    do_reset(); upd(13'h002, 0); chk("R2 underflow", status_q, 32'h8800_0000);
    do_reset(); upd(13'h004, 0); chk("R2 zero divide", status_q, 32'h8400_0000);
    do_reset(); upd(13'h008, 0); chk("R2 inexact", status_q, 32'h8200_0000);
    chk("R6 no trap when disabled", {31'h0, trap_q}, 32'h0);
    do_reset(); upd(13'h000, 0); chk("R1 zero vector on clean word", status_q, 32'h0);
  endtask

  task automatic t_invalid();
    int pos[9] = '{24, 23, 22, 21, 20, 19, 10, 9, 8};
    for (int i = 0; i < 9; i++) begin
      do_reset();
      upd(13'(1 << (4 + i)), 1);
      chk($sformatf("R3 R4 invalid cause %0d", i), status_q,
          32'hA000_0000 | (32'h1 << pos[i]));
      chk("R7 crf after invalid", {28'h0, crf_q}, 32'hA);
    end
  endtask

  task automatic t_trap();
    do_reset();
    sw_set(6);
    chk("R11 bit set", status_q, 32'h0000_0040);
    chk("R6 no trap on sw", {31'h0, trap_q}, 32'h0);
    upd(13'h001, 1);
    chk("R5 overflow enabled", status_q, 32'hD000_0040);
    chk("R6 trap pulse", {31'h0, trap_q}, 32'h1);
    chk("R7 crf", {28'h0, crf_q}, 32'hD);
    cyc();
    chk("R6 trap drops", {31'h0, trap_q}, 32'h0);
    do_reset(); sw_set(4); upd(13'h008, 0);
    chk("R5 unmatched pair", status_q, 32'h8200_0010);
    chk("R6 unmatched no trap", {31'h0, trap_q}, 32'h0);
    do_reset(); sw_set(7); upd(13'h010, 0);
    chk("R5 invalid enabled", status_q, 32'hE100_0080);
    chk("R6 invalid trap", {31'h0, trap_q}, 32'h1);
  endtask

  task automatic t_recompute();
    do_reset();
    upd(13'h010, 0);
    sw_clr(29);
    chk("R11 bit clear", status_q, 32'h8100_0000);
    upd(13'h000, 0);
    chk("R10 invalid summary restored", status_q, 32'hA100_0000);
    sw_set(30);
    chk("R11 forced enabled summary", status_q, 32'hE100_0000);
    upd(13'h000, 0);
    chk("R10 enabled summary dropped", status_q, 32'hA100_0000);
    chk("R6 no trap after recompute", {31'h0, trap_q}, 32'h0);
    upd(13'h001, 0);
    chk("R9 stickies kept", status_q, 32'hB100_0000);
  endtask

  task automatic t_software();
    do_reset();
    idle(); sw_fld_wr = 1; sw_fld_idx = 3'd7; sw_fld_data = 4'h5; cyc(); idle();
    chk("R11 nibble write", status_q, 32'h5000_0000);
    idle(); sw_bit_set = 1; sw_bit_clr = 1; sw_bit_idx = 5'd2; cyc(); idle();
    chk("R11 set wins", status_q, 32'h5000_0004);
    sw_clr(30);
    chk("R11 clear", status_q, 32'h1000_0004);
    idle(); sw_fld_wr = 1; sw_fld_idx = 3'd0; sw_fld_data = 4'h0;
    sw_bit_set = 1; sw_bit_idx = 5'd1; cyc(); idle();
    chk("R11 nibble over bit op", status_q, 32'h1000_0000);
    idle(); sw_bit_set = 1; sw_bit_idx = 5'd3; upd_valid = 1; upd_events = 13'h008;
    cyc(); idle();
    chk("R11 events on sw result", status_q, 32'hD200_0008);
    chk("R6 trap combined", {31'h0, trap_q}, 32'h1);
    idle(); upd_record = 1; cyc(); idle();
    chk("R8 record without update", {28'h0, crf_q}, 32'h0);
    upd(13'h000, 1);
    chk("R7 record zero vector", {28'h0, crf_q}, 32'hD);
    upd(13'h000, 0);
    chk("R8 hold without record", {28'h0, crf_q}, 32'hD);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R12: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_events();
    t_invalid();
    t_trap();
    t_recompute();
    t_software();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule